// File: doc/BRIEF.md
# UART Fractional Baud Tick and Frame Configuration

This block sits in front of a UART shifter. It produces the 16x oversampling tick that paces the serial sampler and the bit-period tick that paces the shifter. Both come from a reference clock, an integer divisor and a small fractional trim. It also turns the line-control register into the frame settings the shifter needs: the number of data bits, the number of stop bits, the parity mode and an infrared-mode flag.

The divisor and the fractional value set the length of one bit period to 16*DIV + FRAC + 16 reference clocks. The 16*DIV product is limited to 16 bits. The fractional clocks are spread one each over the first FRAC oversample ticks of every bit period, so each oversample tick lasts DIV+1 or DIV+2 clocks. A divisor register of zero stops both ticks. Any write to the divisor or the fractional register restarts the tick counters from zero. The new timing therefore begins at a known edge.

Top module: `uart_bclk_cfg`

## Requirements
- R1: After reset the divisor, fractional and line-control registers are zero. Neither tick is asserted, data_bits is 5, two_stop is 0, parity_en is 0, parity_even is 0 and ir_mode is 0.
- R2: While the divisor register holds zero, os_tick and bit_tick stay low.
- R3: Number the oversample ticks of a bit period j = 0..15. Tick j lasts D+1 reference clocks, plus one more clock when j < F. D is the effective divisor and F is the effective fractional value.
- R4: One bit period lasts 16*D + F + 16 clocks. bit_tick is high only in the cycle of the sixteenth oversample tick (j = 15) of each period.
- R5: Only fractional bits [2:0] take effect. Bit 3 has no effect on the timing.
- R6: The 16*D product is limited to 16 bits, so D equals divisor bits [11:0]. A nonzero divisor whose low 12 bits are zero gives an oversample tick on every clock.
- R7: A write to the divisor or the fractional register restarts the counters at the write edge. The first oversample tick is then high in the cycle that ends D+1 (+1 if F>0) clocks after that edge, and it has index j = 0.
- R8: data_bits equals line-control bits [1:0] plus 5, giving 5 to 8.
- R9: Line-control bit 2 set gives two_stop = 1. Bit 2 clear gives two_stop = 0.
- R10: Line-control bit 5 enables parity. When it is set, bit 3 selects the sense: clear for odd, set for even (parity_even = 1). Bit 4 has no effect. With bit 5 clear, parity_en and parity_even are 0.
- R11: Line-control bit 6 drives ir_mode.
- R12: A line-control write does not disturb tick timing. Its decoded fields are visible in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_we | input | 1 | Divisor register write strobe |
| div_wdata | input | 16 | Divisor write value |
| frac_we | input | 1 | Fractional register write strobe |
| frac_wdata | input | 4 | Fractional write value (bits [2:0] used) |
| lcr_we | input | 1 | Line-control register write strobe |
| lcr_wdata | input | 8 | Line-control write value |
| os_tick | output | 1 | 16x oversample tick, one clock wide |
| bit_tick | output | 1 | Bit-period tick, one clock wide, on the last oversample tick |
| data_bits | output | 4 | Data bits per frame (5 to 8) |
| two_stop | output | 1 | 1: two stop bits, 0: one stop bit |
| parity_en | output | 1 | Parity bit present |
| parity_even | output | 1 | Even parity when enabled, odd when 0 |
| ir_mode | output | 1 | Infrared-mode flag |

## Verification
Two events can fall in the same cycle: a divisor or fractional write, and the end of an oversample or bit period. The restart must win, so the counters start from zero and no bit tick can follow in the next cycle.

The bench provokes this by rewriting the divisor partway through a running bit period. It then checks that the first tick after the write arrives exactly D+1 (+1 if F>0) clocks after the write edge, and that the following sixteen ticks rebuild a full bit period. A line-control write in the middle of a period is judged the same way: the tick spacing after it must be unchanged.

// File: rtl/uart_bclk_pkg.sv
package uart_bclk_pkg;

    // Smallest character length a frame may carry
    localparam int unsigned MIN_DATA_BITS = 5;

    // Line-control field positions (decoded by the frame decoder)
    localparam int unsigned LC_LEN_LSB   = 0;
    localparam int unsigned LC_STOP_BIT  = 2;
    localparam int unsigned LC_PSENSE    = 3;
    localparam int unsigned LC_PENABLE   = 5;
    localparam int unsigned LC_IRDA      = 6;

    typedef enum logic [1:0] {
        PAR_OFF  = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_EVEN = 2'd2
    } par_mode_e;

    typedef struct packed {
        logic [3:0] data_bits;
        logic       two_stop;
        par_mode_e  parity;
        logic       ir_mode;
    } frame_cfg_t;

endpackage

// File: rtl/uart_bclk_frame_dec.sv
module uart_bclk_frame_dec
    import uart_bclk_pkg::*;
#(
    parameter int unsigned LCR_W = 8
) (
    input  logic [LCR_W-1:0] lcr,
    output frame_cfg_t       frame
);

    logic [1:0] len_code;
    logic       unused_lcr;

    assign len_code = lcr[LC_LEN_LSB +: 2];

    // Bits outside the decoded fields, plus the ignored sub-field bit 4
    assign unused_lcr = ^{lcr[LCR_W-1:LC_IRDA+1], lcr[4]};

    always_comb begin
        frame           = '0;
        frame.data_bits = 4'(len_code) + 4'(MIN_DATA_BITS);
        frame.two_stop  = lcr[LC_STOP_BIT];
        frame.ir_mode   = lcr[LC_IRDA];
        if (!lcr[LC_PENABLE]) begin
            frame.parity = PAR_OFF;
        end else if (lcr[LC_PSENSE]) begin
            frame.parity = PAR_EVEN;
        end else begin
            frame.parity = PAR_ODD;
        end
    end

endmodule

// File: rtl/uart_bclk_tickgen.sv
module uart_bclk_tickgen #(
    parameter int unsigned EFF_W      = 12,
    parameter int unsigned FRAC_EFF_W = 3,
    parameter int unsigned OS_RATE    = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  restart,
    input  logic                  enable,
    input  logic [EFF_W-1:0]      div_eff,
    input  logic [FRAC_EFF_W-1:0] frac_eff,
    output logic                  os_tick,
    output logic                  bit_tick
);

    localparam int unsigned OS_W  = $clog2(OS_RATE);
    localparam int unsigned CNT_W = EFF_W + 1;
    localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATE - 1);

    typedef struct packed {
        logic [CNT_W-1:0] clk_cnt;
        logic [OS_W-1:0]  os_cnt;
    } tick_st_t;

    tick_st_t         st_d, st_q;
    logic             stretch;
    logic [CNT_W-1:0] limit;
    logic             os_hit;
    logic             last_os;

    always_comb begin
        // The first frac_eff ticks of each bit period carry one extra clock
        stretch  = int'(st_q.os_cnt) < int'(frac_eff);
        limit    = CNT_W'(div_eff) + CNT_W'(stretch);
        os_hit   = enable && (st_q.clk_cnt == limit);
        last_os  = st_q.os_cnt == OS_LAST;

        st_d = st_q;
        if (restart || !enable) begin
            st_d = '0;
        end else if (os_hit) begin
            st_d.clk_cnt = '0;
            st_d.os_cnt  = last_os ? '0 : st_q.os_cnt + 1'b1;
        end else begin
            st_d.clk_cnt = st_q.clk_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign os_tick  = os_hit;
    assign bit_tick = os_hit && last_os;

endmodule

// File: rtl/uart_bclk_cfg.sv
module uart_bclk_cfg
    import uart_bclk_pkg::*;
#(
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned FRAC_W     = 4,
    parameter int unsigned FRAC_EFF_W = 3,
    parameter int unsigned PROD_W     = 16,
    parameter int unsigned OS_RATE    = 16,
    parameter int unsigned LCR_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              frac_we,
    input  logic [FRAC_W-1:0] frac_wdata,
    input  logic              lcr_we,
    input  logic [LCR_W-1:0]  lcr_wdata,
    output logic              os_tick,
    output logic              bit_tick,
    output logic [3:0]        data_bits,
    output logic              two_stop,
    output logic              parity_en,
    output logic              parity_even,
    output logic              ir_mode
);

    // 16*DIV kept to PROD_W bits leaves PROD_W-log2(OS_RATE) divisor bits
    localparam int unsigned OS_SHIFT = $clog2(OS_RATE);
    localparam int unsigned EFF_W    = PROD_W - OS_SHIFT;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [FRAC_W-1:0] frac;
        logic [LCR_W-1:0]  lcr;
    } cfg_regs_t;

    cfg_regs_t             cfg_d, cfg_q;
    logic [EFF_W-1:0]      div_eff;
    logic [FRAC_EFF_W-1:0] frac_eff;
    logic                  gen_en;
    logic                  restart;
    frame_cfg_t            frame;

    always_comb begin
        cfg_d = cfg_q;
        if (div_we) begin
            cfg_d.div = div_wdata;
        end
        if (frac_we) begin
            cfg_d.frac = frac_wdata;
        end
        if (lcr_we) begin
            cfg_d.lcr = lcr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign div_eff  = cfg_q.div[EFF_W-1:0];
    assign frac_eff = cfg_q.frac[FRAC_EFF_W-1:0];
    assign gen_en   = |cfg_q.div;
    assign restart  = div_we | frac_we;

    // Divisor bits above the truncated product only count towards "enabled"
    generate
        if (DIV_W > EFF_W) begin : g_div_hi
            logic unused_div_hi;
            assign unused_div_hi = ^cfg_q.div[DIV_W-1:EFF_W];
        end
        if (FRAC_W > FRAC_EFF_W) begin : g_frac_hi
            logic unused_frac_hi;
            assign unused_frac_hi = ^cfg_q.frac[FRAC_W-1:FRAC_EFF_W];
        end
    endgenerate

    uart_bclk_tickgen #(
        .EFF_W      (EFF_W),
        .FRAC_EFF_W (FRAC_EFF_W),
        .OS_RATE    (OS_RATE)
    ) u_tickgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .enable   (gen_en),
        .div_eff  (div_eff),
        .frac_eff (frac_eff),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );

    uart_bclk_frame_dec #(
        .LCR_W (LCR_W)
    ) u_frame_dec (
        .lcr   (cfg_q.lcr),
        .frame (frame)
    );

    assign data_bits   = frame.data_bits;
    assign two_stop    = frame.two_stop;
    assign parity_en   = frame.parity != PAR_OFF;
    assign parity_even = frame.parity == PAR_EVEN;
    assign ir_mode     = frame.ir_mode;

endmodule

// File: rtl/uart_bclk_cfg_chk.sv
module uart_bclk_cfg_chk #(
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned FRAC_W = 4,
    parameter int unsigned LCR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              div_we,
    input logic [DIV_W-1:0]  div_wdata,
    input logic              frac_we,
    input logic [FRAC_W-1:0] frac_wdata,
    input logic              lcr_we,
    input logic [LCR_W-1:0]  lcr_wdata,
    input logic              os_tick,
    input logic              bit_tick,
    input logic [3:0]        data_bits,
    input logic              two_stop,
    input logic              parity_en,
    input logic              parity_even,
    input logic              ir_mode
);

    // Tracks from the write port whether the divisor register is zero
    logic div_zero_q;
    logic unused_chk;

    assign unused_chk = ^{frac_wdata, parity_even};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_zero_q <= 1'b1;
        end else if (div_we) begin
            div_zero_q <= (div_wdata == '0);
        end
    end

    AST_IDLE_WHEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_q |-> (!os_tick && !bit_tick)); // R2

    AST_BIT_ON_OS: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick); // R4

    AST_RESTART_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (div_we || frac_we) |=> !bit_tick); // R7

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_bits >= 4'd5) && (data_bits <= 4'd8)); // R8

    AST_STOP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lcr_we |=> (two_stop == $past(lcr_wdata[2]))); // R9

    AST_PAR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lcr_we |=> (parity_en == $past(lcr_wdata[5]))); // R10

    AST_IR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lcr_we |=> (ir_mode == $past(lcr_wdata[6]))); // R11

    AST_LCR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lcr_we |=> $stable(data_bits)); // R12

endmodule

bind uart_bclk_cfg uart_bclk_cfg_chk #(
    .DIV_W  (DIV_W),
    .FRAC_W (FRAC_W),
    .LCR_W  (LCR_W)
) u_chk (.*);

// File: tb/uart_bclk_cfg_bench.sv
`timescale 1ns/1ps
module uart_bclk_cfg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_we = 1'b0;
    logic [15:0] div_wdata = '0;
    logic        frac_we = 1'b0;
    logic [3:0]  frac_wdata = '0;
    logic        lcr_we = 1'b0;
    logic [7:0]  lcr_wdata = '0;
    logic        os_tick, bit_tick;
    logic [3:0]  data_bits;
    logic        two_stop, parity_en, parity_even, ir_mode;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    uart_bclk_cfg u_uart_bclk_cfg (.*);

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write one register; returns just after the capturing edge
    task automatic wr(input int sel, input int val);
        @(negedge clk);
        case (sel)
            0: begin div_we = 1'b1;  div_wdata  = 16'(val); end
            1: begin frac_we = 1'b1; frac_wdata = 4'(val);  end
            default: begin lcr_we = 1'b1; lcr_wdata = 8'(val); end
        endcase
        @(posedge clk);
        #1;
        div_we = 1'b0; frac_we = 1'b0; lcr_we = 1'b0;
    endtask

    // Count sampling points until os_tick is seen
    task automatic next_os(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!os_tick && n < 300);
    endtask

    // Measure cnt oversample ticks from a restart; adj corrects the first one
    task automatic measure(input string req, input int d, input int f,
                           input int cnt, input int adj);
        int sum = 0;
        for (int j = 0; j < cnt; j++) begin
            int n;
            int exp_n;
            next_os(n);
            exp_n = d + 1 + (((j % 16) < f) ? 1 : 0) + ((j == 0) ? adj : 0);
            check({req, " R3 tick length"}, n, exp_n);
            check({req, " R4 bit tick position"}, int'(bit_tick),
                  ((j % 16) == 15) ? 1 : 0);
            sum += n;
            if ((j % 16) == 15) begin
                check({req, " R4 bit period"}, sum - ((j < 16) ? adj : 0),
                      16 * d + f + 16);
                sum = 0;
            end
        end
    endtask

    task automatic t_reset();
        check("R1 os_tick", int'(os_tick), 0);
        check("R1 bit_tick", int'(bit_tick), 0);
        check("R1 data_bits", int'(data_bits), 5);
        check("R1 two_stop", int'(two_stop), 0);
        check("R1 parity_en", int'(parity_en), 0);
        check("R1 parity_even", int'(parity_even), 0);
        check("R1 ir_mode", int'(ir_mode), 0);
    endtask

    task automatic t_idle(input string req);
        int seen = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (os_tick || bit_tick) seen++;
        end
        check(req, seen, 0);
    endtask

    task automatic t_integer();
        wr(1, 0);
        wr(0, 3);
        measure("R7 integer div3", 3, 0, 32, 0);
    endtask

    task automatic t_fraction();
        wr(0, 2);
        wr(1, 5);
        measure("R3 frac5 div2", 2, 5, 32, 0);
    endtask

    task automatic t_frac_mask();
        wr(1, 13);
        measure("R5 frac bit3 ignored", 2, 5, 32, 0);
    endtask

    task automatic t_trunc();
        wr(1, 0);
        wr(0, 16'h1001);
        measure("R6 div 0x1001", 1, 0, 16, 0);
        wr(0, 16'h1000);
        measure("R6 div 0x1000", 0, 0, 32, 0);
    endtask

    task automatic t_restart();
        int n;
        wr(1, 2);
        wr(0, 3);
        next_os(n);
        next_os(n);
        @(negedge clk);
        @(negedge clk);
        wr(0, 3);
        measure("R7 restart mid period", 3, 2, 32, 0);
    endtask

    task automatic t_lcr();
        wr(2, 8'h03); check("R8 len code 3", int'(data_bits), 8);
        wr(2, 8'h02); check("R8 len code 2", int'(data_bits), 7);
        wr(2, 8'h04); check("R9 two stop", int'(two_stop), 1);
        check("R8 len code 0", int'(data_bits), 5);
        wr(2, 8'h00); check("R9 one stop", int'(two_stop), 0);
        wr(2, 8'h20);
        check("R10 odd en", int'(parity_en), 1);
        check("R10 odd sense", int'(parity_even), 0);
        wr(2, 8'h28);
        check("R10 even en", int'(parity_en), 1);
        check("R10 even sense", int'(parity_even), 1);
        wr(2, 8'h38); check("R10 bit4 ignored", int'(parity_even), 1);
        wr(2, 8'h18);
        check("R10 no enable", int'(parity_en), 0);
        check("R10 no enable sense", int'(parity_even), 0);
        wr(2, 8'h40); check("R11 ir on", int'(ir_mode), 1);
        wr(2, 8'h00); check("R11 ir off", int'(ir_mode), 0);
    endtask

    task automatic t_lcr_while_running();
        wr(1, 3);
        wr(0, 2);
        wr(2, 8'h6D);
        check("R12 fields after write", int'(data_bits), 6);
        check("R12 stop after write", int'(two_stop), 1);
        measure("R12 timing after lcr write", 2, 3, 32, -1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_idle("R2 idle after reset");
        t_integer();
        t_fraction();
        t_frac_mask();
        t_trunc();
        t_restart();
        t_lcr();
        t_lcr_while_running();
        wr(0, 0);
        t_idle("R2 zero divisor stops ticks");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule